// File: doc/BRIEF.md
# Programmable 32-bit Interval and Wall-Clock Timer

This block is a general-purpose counter that software sets up through a small word-addressed register bank. One counter serves three behaviours. A configuration value picks either timeout operation or wall-clock operation. In timeout operation a mode field then picks single-shot or repeating countdown. Software programs the interval, arms the timer with an enable bit, and either watches the raw status register or takes the masked interrupt line.

In wall-clock operation the counter counts up. It advances once per rising edge of a slow external reference clock, which is first brought into the system clock domain. When the count advances onto the programmed compare value, a sticky match flag is raised. The count then carries on through the all-ones value and wraps to zero. Writing a new start value while the timer is running restarts the count from that value. A stall input can freeze the counter, but only when software has opted in through a control bit.

Register words (4-bit address): 0 selects operation (3 bits, 0 = timeout, 1 = wall-clock), 1 holds the countdown style (2 bits, 1 = single-shot, 2 = repeating), 2 holds control (bit 0 enable, bit 1 stall opt-in), 3 holds the start value, 4 holds the compare value, 5 is raw status (read-only, bit 0 timeout, bit 1 match), 6 is the interrupt mask (same bit layout), 7 clears status when written (write-one-to-clear, reads as 0), and 8 reads the live count.

Top module: `gp_timer32`

## Requirements
- R1: After reset every register word reads 0, and the timeout, match and interrupt outputs are low.
- R2: Writes to the operation word (0) and the countdown-style word (1) are ignored while the enable bit is set.
- R3: Writing control with bit 0 set while the timer is disabled loads the count from the start value on that same clock edge.
- R4: In single-shot mode (operation 0, style 1) the count decrements once per cycle down to 0. On the cycle after it reaches 0, the timeout flag (status bit 0) sets and the enable bit clears. The count then stays at 0.
- R5: In repeating mode (operation 0, style 2) the count runs from the start value L down to 0 and then reloads L. The timeout flag sets every L+1 cycles, and enable stays set.
- R6: In wall-clock mode (operation 1) each rising edge of `rtc_clk_i` increments the count by one. The new value is visible on the second clock edge after the first clock edge that samples the high level.
- R7: In wall-clock mode, the increment that makes the count equal the compare value sets the match flag (status bit 1). Counting continues.
- R8: In wall-clock mode the count wraps from 0xFFFFFFFF to 0.
- R9: In wall-clock mode, writing the start value while enabled reloads the count from the written value at once.
- R10: Writing a 1 to a bit of the clear word (7) clears that status bit. A status event on the same edge wins over the clear.
- R11: `irq_o` is high exactly when some status bit is set and its mask bit (word 6) is also set.
- R12: While `stall_i` is high and the stall opt-in bit (control bit 1) is set, the count holds. With the opt-in bit clear, `stall_i` has no effect.
- R13: In timeout operation with a style value other than 1 or 2, the count holds and no timeout is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| rtc_clk_i | input | 1 | Slow wall-clock reference, asynchronous |
| stall_i | input | 1 | Freeze request |
| timeout_o | output | 1 | Raw timeout status |
| match_o | output | 1 | Raw wall-clock match status |
| irq_o | output | 1 | Masked interrupt |

## Verification
If the count register is corrupted, the error shows up on the count readback word in the very next cycle. In timeout mode it also moves the timeout flag off its expected L+1 cycle boundary, and a scoreboard catches that on the exact edge. A fault in the synchronizer or its edge detector shifts the cycle on which each wall-clock increment lands, or makes an increment land twice. Two scheduled count samples around each reference edge pin that latency down to one cycle. A lost lock on the operation words, or a bad clear or set priority, is exposed on the next readback of the affected word.

// File: rtl/gpt_pkg.sv
// Shared constants for the interval/wall-clock timer.
// Assumes a 4-bit word address and status bit 0 = timeout, bit 1 = match.
package gpt_pkg;
    localparam int ADDR_W = 4;
    localparam int CFG_W  = 3;
    localparam int MODE_W = 2;
    localparam int ST_W   = 2;

    localparam logic [ADDR_W-1:0] A_CFG   = 4'd0;
    localparam logic [ADDR_W-1:0] A_MODE  = 4'd1;
    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd2;
    localparam logic [ADDR_W-1:0] A_LOAD  = 4'd3;
    localparam logic [ADDR_W-1:0] A_MATCH = 4'd4;
    localparam logic [ADDR_W-1:0] A_RIS   = 4'd5;
    localparam logic [ADDR_W-1:0] A_IMR   = 4'd6;
    localparam logic [ADDR_W-1:0] A_ICR   = 4'd7;
    localparam logic [ADDR_W-1:0] A_COUNT = 4'd8;

    localparam logic [CFG_W-1:0]  CFG_TIMER = 3'd0;
    localparam logic [CFG_W-1:0]  CFG_RTC   = 3'd1;
    localparam logic [MODE_W-1:0] MODE_ONE  = 2'd1;
    localparam logic [MODE_W-1:0] MODE_PER  = 2'd2;

    localparam int ST_TO  = 0;
    localparam int ST_MAT = 1;
endpackage

// File: rtl/gpt_sync.sv
// Brings the asynchronous wall-clock reference into the system domain
// through STAGES flops and emits a one-cycle pulse on its rising edge.
// Assumes the reference is much slower than clk.
module gpt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/gpt_regs.sv
// Register bank: holds configuration, control, start/compare values,
// mask and sticky status; produces the count-load strobe.
// Assumes one write per cycle; status set wins over clear.
module gpt_regs
    import gpt_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     count_i,
    input  logic              ev_to_i,
    input  logic              ev_match_i,
    input  logic              done_i,
    output logic [DW-1:0]     rdata,
    output logic [CFG_W-1:0]  cfg_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              en_o,
    output logic              stall_en_o,
    output logic [DW-1:0]     load_o,
    output logic [DW-1:0]     cmp_o,
    output logic [ST_W-1:0]   ris_o,
    output logic [ST_W-1:0]   imr_o,
    output logic              strobe_o,
    output logic [DW-1:0]     strobe_val_o
);
    logic [ST_W-1:0] set_v, clr_v;
    logic            wr_ctrl, wr_load;

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_load = wr_en && (addr == A_LOAD);
    assign set_v   = {ev_match_i, ev_to_i};
    assign clr_v   = (wr_en && addr == A_ICR) ? wdata[ST_W-1:0] : '0;

    // Start on arming, or restart on a start-value write in wall-clock mode.
    assign strobe_o     = (wr_ctrl && wdata[0] && !en_o) ||
                          (wr_load && en_o && cfg_o == CFG_RTC);
    assign strobe_val_o = wr_load ? wdata : load_o;

    // Configuration words, locked while the timer is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o  <= '0;
            mode_o <= '0;
        end else if (wr_en && !en_o) begin
            if (addr == A_CFG)  cfg_o  <= wdata[CFG_W-1:0];
            if (addr == A_MODE) mode_o <= wdata[MODE_W-1:0];
        end
    end

    // Control bits; single-shot completion drops enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o       <= 1'b0;
            stall_en_o <= 1'b0;
        end else if (wr_ctrl) begin
            en_o       <= wdata[0];
            stall_en_o <= wdata[1];
        end else if (done_i) begin
            en_o       <= 1'b0;
        end
    end

    // Data words: start value, compare value and interrupt mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_o <= '0;
            cmp_o  <= '0;
            imr_o  <= '0;
        end else if (wr_en) begin
            if (addr == A_LOAD)  load_o <= wdata;
            if (addr == A_MATCH) cmp_o  <= wdata;
            if (addr == A_IMR)   imr_o  <= wdata[ST_W-1:0];
        end
    end

    // Sticky status with write-one-to-clear; a new event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) ris_o <= '0;
        else        ris_o <= (ris_o & ~clr_v) | set_v;
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CFG:   rdata[CFG_W-1:0]  = cfg_o;
            A_MODE:  rdata[MODE_W-1:0] = mode_o;
            A_CTRL:  rdata[1:0]        = {stall_en_o, en_o};
            A_LOAD:  rdata             = load_o;
            A_MATCH: rdata             = cmp_o;
            A_RIS:   rdata[ST_W-1:0]   = ris_o;
            A_IMR:   rdata[ST_W-1:0]   = imr_o;
            A_COUNT: rdata             = count_i;
            default: rdata             = '0;
        endcase
    end

    // R2: operation word cannot change while armed.
    p_cfg_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && wr_en && addr == A_CFG) |=> $stable(cfg_o));
    // R4: single-shot completion disarms the timer.
    p_oneshot_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !wr_ctrl) |=> !en_o);
    // R10: a clear without a coincident event removes the timeout flag.
    p_clear_to_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_ICR && wdata[ST_TO] && !ev_to_i) |=> !ris_o[ST_TO]);
endmodule

// File: rtl/gpt_counter.sv
// The shared counter: counts down in timeout operation, up on reference
// edges in wall-clock operation, and raises timeout/match events.
// Assumes strobe has priority over any counting in the same cycle.
module gpt_counter
    import gpt_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [CFG_W-1:0]  cfg_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              stall_i,
    input  logic              stall_en_i,
    input  logic [DW-1:0]     load_i,
    input  logic [DW-1:0]     cmp_i,
    input  logic              tick_i,
    input  logic              strobe_i,
    input  logic [DW-1:0]     strobe_val_i,
    output logic [DW-1:0]     count_o,
    output logic              ev_to_o,
    output logic              ev_match_o,
    output logic              done_o
);
    logic          frozen, timer_mode, rtc_mode, at_zero, run;
    logic [DW-1:0] up_val;

    assign frozen     = stall_i && stall_en_i;
    assign timer_mode = (cfg_i == CFG_TIMER) && (mode_i == MODE_ONE || mode_i == MODE_PER);
    assign rtc_mode   = (cfg_i == CFG_RTC);
    assign at_zero    = (count_o == '0);
    assign run        = en_i && !frozen && !strobe_i;
    assign up_val     = count_o + 1'b1;

    assign ev_to_o    = run && timer_mode && at_zero;
    assign done_o     = ev_to_o && (mode_i == MODE_ONE);
    assign ev_match_o = run && rtc_mode && tick_i && (up_val == cmp_i);

    // Count update: load, then down-count / reload, or reference-driven up-count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (strobe_i) begin
            count_o <= strobe_val_i;
        end else if (en_i && !frozen) begin
            if (timer_mode) begin
                if (!at_zero)               count_o <= count_o - 1'b1;
                else if (mode_i == MODE_PER) count_o <= load_i;
            end else if (rtc_mode && tick_i) begin
                count_o <= up_val;
            end
        end
    end

    // R3: a load strobe places its value in the count.
    p_start_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> count_o == $past(strobe_val_i));
    // R5: a running countdown steps by exactly one.
    p_down_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && timer_mode && !at_zero) |=> count_o == $past(count_o) - 1'b1);
    // R6: a reference edge in wall-clock mode steps up by one.
    p_up_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && rtc_mode && tick_i) |=> count_o == $past(count_o) + 1'b1);
    // R12: an honoured stall holds the count.
    p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !strobe_i) |=> $stable(count_o));
endmodule

// File: rtl/gp_timer32.sv
// Top of the interval/wall-clock timer: synchronizer, register bank and
// counter; drives raw flags and the masked interrupt.
// Assumes rtc_clk_i is asynchronous and slow relative to clk.
module gp_timer32
    import gpt_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic              rtc_clk_i,
    input  logic              stall_i,
    output logic              timeout_o,
    output logic              match_o,
    output logic              irq_o
);
    logic              tick, en, stall_en, strobe, ev_to, ev_match, done;
    logic [CFG_W-1:0]  cfg;
    logic [MODE_W-1:0] mode;
    logic [CNT_W-1:0]  load, cmp, count, strobe_val;
    logic [ST_W-1:0]   ris, imr;

    gpt_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(rtc_clk_i), .rise_o(tick)
    );

    gpt_regs #(.DW(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .count_i(count), .ev_to_i(ev_to), .ev_match_i(ev_match), .done_i(done),
        .rdata(rdata), .cfg_o(cfg), .mode_o(mode), .en_o(en),
        .stall_en_o(stall_en), .load_o(load), .cmp_o(cmp), .ris_o(ris),
        .imr_o(imr), .strobe_o(strobe), .strobe_val_o(strobe_val)
    );

    gpt_counter #(.DW(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en_i(en), .cfg_i(cfg), .mode_i(mode),
        .stall_i(stall_i), .stall_en_i(stall_en), .load_i(load), .cmp_i(cmp),
        .tick_i(tick), .strobe_i(strobe), .strobe_val_i(strobe_val),
        .count_o(count), .ev_to_o(ev_to), .ev_match_o(ev_match), .done_o(done)
    );

    assign timeout_o = ris[ST_TO];
    assign match_o   = ris[ST_MAT];
    assign irq_o     = |(ris & imr);

    // R7: a match event is recorded on the next edge.
    p_match_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_match |=> match_o);
endmodule

// File: tb/gp_timer32_tb_top.sv
`timescale 1ns/100ps
module gp_timer32_tb_top;
    localparam logic [3:0] W_CFG = 4'd0, W_MODE = 4'd1, W_CTRL = 4'd2, W_LOAD = 4'd3,
                           W_MATCH = 4'd4, W_RIS = 4'd5, W_IMR = 4'd6, W_ICR = 4'd7,
                           W_COUNT = 4'd8;
    localparam int SEL_RD = 0, SEL_TO = 1, SEL_MAT = 2, SEL_IRQ = 3;

    typedef struct {
        int          cyc;
        int          sel;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rtc_clk_i = 1'b0, stall_i = 1'b0;
    logic [3:0]  addr = W_COUNT;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        timeout_o, match_o, irq_o;

    int    cyc = 0, n_chk = 0, n_fail = 0, c0 = 0, dummy = 0;
    logic [31:0] rtc_exp, sampled;
    item_t sb[$];

    gp_timer32 dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rtc_clk_i(rtc_clk_i), .stall_i(stall_i),
        .timeout_o(timeout_o), .match_o(match_o), .irq_o(irq_o)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push(input int c, input int sel, input logic [31:0] exp, input string req);
        item_t it;
        it.cyc = c; it.sel = sel; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    // Driver: one register write; returns the edge number it lands on.
    task automatic wr(input logic [3:0] a, input logic [31:0] d, output int edge_no);
        wr_en = 1'b1; addr = a; wdata = d; edge_no = cyc + 1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; addr = W_COUNT; wdata = '0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
        addr = a; #1;
        check(rdata, exp, req);
        addr = W_COUNT;
    endtask

    task automatic rd_val(input logic [3:0] a, output logic [31:0] v);
        addr = a; #1;
        v = rdata;
        addr = W_COUNT;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // One reference pulse; scoreboard expects the count one and two edges later.
    task automatic rtc_pulse(input string req);
        int a;
        rtc_clk_i = 1'b1; a = cyc + 1;
        push(a + 1, SEL_RD, rtc_exp, req);
        rtc_exp = rtc_exp + 1;
        push(a + 2, SEL_RD, rtc_exp, req);
        repeat (4) @(negedge clk);
        rtc_clk_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Monitor: pops scheduled expectations and compares just after each edge.
    initial begin
        forever begin
            item_t it;
            logic [31:0] act;
            @(posedge clk); #1;
            while (sb.size() > 0 && sb[0].cyc <= cyc) begin
                it = sb.pop_front();
                case (it.sel)
                    SEL_TO:  act = {31'd0, timeout_o};
                    SEL_MAT: act = {31'd0, match_o};
                    SEL_IRQ: act = {31'd0, irq_o};
                    default: act = rdata;
                endcase
                if (it.cyc < cyc) check(32'hDEAD_BEEF, it.exp, {it.req, " missed"});
                else              check(act, it.exp, it.req);
            end
        end
    end

    // Watchdog.
    initial begin
        #(5 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int w = 0; w <= 8; w++) rd_chk(w[3:0], 32'd0, "R1");
        check({29'd0, timeout_o, match_o, irq_o}, 32'd0, "R1 outputs");

        // R4 / R3: single-shot, start value 5
        wr(W_MODE, 32'd1, dummy);
        wr(W_LOAD, 32'd5, dummy);
        wr(W_IMR, 32'd1, dummy);
        wr(W_CTRL, 32'd1, c0);
        rd_chk(W_COUNT, 32'd5, "R3");
        push(c0 + 1, SEL_RD, 32'd4, "R4");
        push(c0 + 5, SEL_RD, 32'd0, "R4");
        push(c0 + 5, SEL_TO, 32'd0, "R4");
        push(c0 + 6, SEL_TO, 32'd1, "R4");
        push(c0 + 6, SEL_IRQ, 32'd1, "R11");
        push(c0 + 7, SEL_RD, 32'd0, "R4");
        wait_to(c0 + 8);
        rd_chk(W_CTRL, 32'd0, "R4 enable cleared");

        // R10 / R11: clearing drops status and interrupt
        wr(W_ICR, 32'd1, dummy);
        rd_chk(W_RIS, 32'd0, "R10");
        check({31'd0, irq_o}, 32'd0, "R11");

        // R5: repeating, start value 3
        wr(W_MODE, 32'd2, dummy);
        wr(W_LOAD, 32'd3, dummy);
        wr(W_CTRL, 32'd1, c0);
        push(c0 + 1, SEL_RD, 32'd2, "R5");
        push(c0 + 3, SEL_RD, 32'd0, "R5");
        push(c0 + 4, SEL_RD, 32'd3, "R5");
        push(c0 + 4, SEL_TO, 32'd1, "R5");
        push(c0 + 5, SEL_RD, 32'd2, "R5");
        wait_to(c0 + 7);
        wr(W_ICR, 32'd1, dummy);            // lands with the second timeout
        rd_chk(W_RIS, 32'd1, "R10 set wins");
        wr(W_ICR, 32'd1, dummy);
        rd_chk(W_RIS, 32'd0, "R10");
        // R2: locked configuration while enabled
        wr(W_MODE, 32'd1, dummy);
        rd_chk(W_MODE, 32'd2, "R2");
        wr(W_CFG, 32'd1, dummy);
        rd_chk(W_CFG, 32'd0, "R2");
        rd_chk(W_CTRL, 32'd1, "R5 stays enabled");
        wr(W_CTRL, 32'd0, dummy);
        wr(W_ICR, 32'd3, dummy);

        // R12: stall honoured, then ignored
        wr(W_LOAD, 32'd100, dummy);
        wr(W_CTRL, 32'd3, c0);
        repeat (2) @(negedge clk);
        stall_i = 1'b1;
        repeat (5) @(negedge clk);
        rd_chk(W_COUNT, 32'd98, "R12 hold");
        stall_i = 1'b0;
        wr(W_CTRL, 32'd1, dummy);
        rd_val(W_COUNT, sampled);
        stall_i = 1'b1;
        repeat (3) @(negedge clk);
        rd_chk(W_COUNT, sampled - 32'd3, "R12 ignored");
        stall_i = 1'b0;
        wr(W_CTRL, 32'd0, dummy);
        wr(W_ICR, 32'd3, dummy);

        // R13: unsupported style holds
        wr(W_MODE, 32'd3, dummy);
        wr(W_LOAD, 32'd4, dummy);
        wr(W_CTRL, 32'd1, dummy);
        repeat (10) @(negedge clk);
        rd_chk(W_COUNT, 32'd4, "R13");
        rd_chk(W_RIS, 32'd0, "R13");
        wr(W_CTRL, 32'd0, dummy);

        // R6..R9: wall-clock operation
        wr(W_CFG, 32'd1, dummy);
        wr(W_LOAD, 32'hFFFF_FFFC, dummy);
        wr(W_MATCH, 32'hFFFF_FFFE, dummy);
        wr(W_IMR, 32'd2, dummy);
        wr(W_CTRL, 32'd1, dummy);
        rd_chk(W_COUNT, 32'hFFFF_FFFC, "R3");
        rtc_exp = 32'hFFFF_FFFC;
        rtc_pulse("R6");
        check({31'd0, match_o}, 32'd0, "R7 before");
        rtc_pulse("R7");
        check({31'd0, match_o}, 32'd1, "R7");
        check({31'd0, irq_o}, 32'd1, "R11");
        rtc_pulse("R8");
        rtc_pulse("R8");
        rd_chk(W_COUNT, 32'd0, "R8 wrap");
        rd_chk(W_CTRL, 32'd1, "R7 keeps running");
        wr(W_LOAD, 32'd10, dummy);
        rd_chk(W_COUNT, 32'd10, "R9");
        rtc_exp = 32'd10;
        rtc_pulse("R9");
        wr(W_ICR, 32'd2, dummy);
        check({31'd0, match_o}, 32'd0, "R10");
        check({31'd0, irq_o}, 32'd0, "R11");

        repeat (4) @(negedge clk);
        check(sb.size(), 32'd0, "scoreboard drained");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule